// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the SDRAM command pins from reset until the memory is usable, and from then on it schedules periodic auto-refresh. After reset it drives NOP with clock enable and all data-mask bits high for a wait of a programmable number of microseconds. It then issues a precharge of all banks, a programmable number of auto-refresh commands, and a load of the mode register. Each command is separated from the next by a counted gap: the precharge time after a precharge, the refresh cycle time after a refresh, and the mode-register gap after the mode load. When that last gap has elapsed, `ready_o` rises and the data masks are released.

After initialization, an interval timer adds one owed refresh every refresh period, and `ref_req_o` stays high while any refresh is owed. The surrounding controller grants the request once its own traffic has stopped. The sequencer then closes every bank with a precharge-all and issues the auto-refresh one precharge time later. The refresh therefore always starts with all banks precharged. Owed refreshes accumulate up to a fixed limit, so the controller may postpone several of them and catch up later.

All counts come from parameters. The clock frequency in MHz multiplied by the wait in microseconds gives the wait length. The clock frequency multiplied by the refresh period in nanoseconds, divided by 1000, gives the refresh interval. The default values are 10000 and 780 clocks at 50 MHz.

Top module: `sdram_pwrup_refresh`

## Requirements
- R1: While reset is asserted and during the initial wait, the pins carry NOP (CS low; RAS, CAS and WE high), every DQM bit is high, and `ready_o` and `ref_req_o` are low. The address and bank outputs are zero.
- R2: The first non-NOP command is a precharge-all, visible exactly WAIT_CYC = CLK_MHZ*WAIT_US rising edges after reset release. It is encoded CS/RAS/CAS/WE = 0/0/1/0, with address bit AP_BIT (10) high and all other address and bank bits zero.
- R3: INIT_REFS auto-refresh commands follow, encoded 0/0/0/1 with address and bank zero. The first comes T_RP edges after the precharge, and each later one comes T_RC edges after the previous one.
- R4: A mode-register load, encoded 0/0/0/0, follows T_RC edges after the last initial refresh. It carries MODE_OP on the address bus and zero on the bank bus.
- R5: `ready_o` rises exactly T_MRD edges after the mode-register load and never falls again. In that same cycle every DQM bit goes low. NOP is driven in every cycle between initialization commands.
- R6: CKE is high in every cycle, both during and after reset.
- R7: After `ready_o` rises, one refresh becomes owed every REFI_CYC = CLK_MHZ*REFI_NS/1000 edges, the first one REFI_CYC edges after the rise. `ref_req_o` is high exactly while at least one refresh is owed.
- R8: If `ref_gnt_i` is high at an edge while `ref_req_o` is high and no refresh is in progress, that edge issues a precharge-all (AP_BIT high). The auto-refresh follows T_RP edges later and removes one owed refresh in the same cycle. No further precharge can follow until T_RC edges after that refresh.
- R9: `ref_gnt_i` has no effect while `ref_req_o` is low, before `ready_o`, or during a refresh in progress. The pins keep NOP in those cases.
- R10: The number of owed refreshes saturates at MAX_DEBT. Once it is reached, further intervals add nothing, so exactly MAX_DEBT refreshes drain the request before `ref_req_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Controller permits a refresh now (banks may be closed) |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_cke_o | output | 1 | Clock enable |
| sd_dqm_o | output | DQM_W | Data mask, high until ready |
| sd_addr_o | output | ADDR_W | Address bus (AP_BIT selects all banks; mode word on load) |
| sd_ba_o | output | BA_W | Bank address |
| ready_o | output | 1 | Initialization complete |
| ref_req_o | output | 1 | At least one refresh is owed |

## Verification
Some properties are checked on every cycle, whatever the stimulus:
- the minimum gap after each command type;
- the all-banks bit on every precharge;
- a precharge immediately before every periodic refresh;
- CKE high at all times, DQM high until ready, and ready never falling;
- `ref_req_o` falling only in a refresh cycle.

The scenarios are needed for the exact edge counts of the power-up order, the interval timing, the saturation of owed refreshes, and the fact that a grant without a request or during a refresh has no effect. To show these, the bench steers the grant with several patterns: held high, withheld long enough to saturate, toggled, and pseudo-random.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_MRS = 2'd3
  } sdr_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_pins_t;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_IREF = 3'd1,
    ST_MRS  = 3'd2,
    ST_MRSW = 3'd3,
    ST_IDLE = 3'd4,
    ST_PREF = 3'd5
  } seq_st_e;

  function automatic sdr_pins_t cmd_pins(sdr_cmd_e c);
    sdr_pins_t p;
    unique case (c)
      CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdr_cmd_timer.sv
// Down-counter that blocks the sequencer until the current gap has elapsed.
module sdr_cmd_timer #(
  parameter int            W    = 8,
  parameter logic [W-1:0]  INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= INIT;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdr_refi_timer.sv
// Refresh interval counter plus saturating count of owed refreshes.
module sdr_refi_timer #(
  parameter int REFI_CYC = 780,
  parameter int MAX_DEBT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  output logic req_o
);

  localparam int CW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam int DW = $clog2(MAX_DEBT + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] debt_q;
  logic          tick;

  assign tick = en_i && (cnt_q == CW'(REFI_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debt_q <= '0;
    end else begin
      unique case ({tick, done_i})
        2'b10:   if (debt_q != DW'(MAX_DEBT)) debt_q <= debt_q + 1'b1;
        2'b01:   if (debt_q != '0)            debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end

  assign req_o = (debt_q != '0);

endmodule

// File: rtl/sdr_pin_drv.sv
// Registers the command pins so every output comes straight from a flop.
module sdr_pin_drv
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 2,
  parameter int DQM_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sdr_cmd_e          cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic              ready_d_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ready_o
);

  sdr_pins_t pins_d;

  assign pins_d = cmd_pins(cmd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o  <= 1'b0;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      cke_o   <= 1'b1;
      dqm_o   <= '1;
      addr_o  <= '0;
      ba_o    <= '0;
      ready_o <= 1'b0;
    end else begin
      cs_n_o  <= pins_d.cs_n;
      ras_n_o <= pins_d.ras_n;
      cas_n_o <= pins_d.cas_n;
      we_n_o  <= pins_d.we_n;
      cke_o   <= 1'b1;
      dqm_o   <= {DQM_W{~ready_d_i}};
      addr_o  <= addr_i;
      ba_o    <= ba_i;
      ready_o <= ready_d_i;
    end
  end

endmodule

// File: rtl/sdram_pwrup_refresh.sv
module sdram_pwrup_refresh
  import sdr_seq_pkg::*;
#(
  parameter int                CLK_MHZ   = 50,
  parameter int                WAIT_US   = 200,
  parameter int                REFI_NS   = 15600,
  parameter int                T_RP      = 3,
  parameter int                T_RC      = 10,
  parameter int                T_MRD     = 2,
  parameter int                INIT_REFS = 2,
  parameter int                MAX_DEBT  = 8,
  parameter int                ADDR_W    = 11,
  parameter int                BA_W      = 2,
  parameter int                DQM_W     = 4,
  parameter int                AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_OP   = 11'h032
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_gnt_i,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic              sd_cke_o,
  output logic [DQM_W-1:0]  sd_dqm_o,
  output logic [ADDR_W-1:0] sd_addr_o,
  output logic [BA_W-1:0]   sd_ba_o,
  output logic              ready_o,
  output logic              ref_req_o
);

  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int REFI_CYC = (CLK_MHZ * REFI_NS) / 1000;
  localparam int GAP_MAX  = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                          : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int TMR_MAX  = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int IR_W     = $clog2(INIT_REFS + 1);

  seq_st_e           st_q, st_d;
  logic [IR_W-1:0]   irefs_q, irefs_d;
  sdr_cmd_e          cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_d;
  logic              tmr_ld;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic              ready_d;
  logic              ref_done;

  sdr_cmd_timer #(
    .W    (TMR_W),
    .INIT (TMR_W'(WAIT_CYC - 1))
  ) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sdr_refi_timer #(
    .REFI_CYC (REFI_CYC),
    .MAX_DEBT (MAX_DEBT)
  ) u_refi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ready_o),
    .done_i (ref_done),
    .req_o  (ref_req_o)
  );

  always_comb begin
    st_d     = st_q;
    irefs_d  = irefs_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    ba_d     = '0;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    ready_d  = ready_o;
    ref_done = 1'b0;
    unique case (st_q)
      ST_WAIT: if (tmr_zero) begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
        tmr_ld         = 1'b1;
        tmr_val        = TMR_W'(T_RP - 1);
        st_d           = ST_IREF;
      end
      ST_IREF: if (tmr_zero) begin
        cmd_d   = CMD_REF;
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(T_RC - 1);
        irefs_d = irefs_q + 1'b1;
        if (irefs_q == IR_W'(INIT_REFS - 1)) st_d = ST_MRS;
      end
      ST_MRS: if (tmr_zero) begin
        cmd_d   = CMD_MRS;
        addr_d  = MODE_OP;
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(T_MRD - 1);
        st_d    = ST_MRSW;
      end
      ST_MRSW: if (tmr_zero) begin
        ready_d = 1'b1;
        st_d    = ST_IDLE;
      end
      ST_IDLE: if (tmr_zero && ref_req_o && ref_gnt_i) begin
        // close every bank before the refresh
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
        tmr_ld         = 1'b1;
        tmr_val        = TMR_W'(T_RP - 1);
        st_d           = ST_PREF;
      end
      ST_PREF: if (tmr_zero) begin
        cmd_d    = CMD_REF;
        ref_done = 1'b1;
        tmr_ld   = 1'b1;
        tmr_val  = TMR_W'(T_RC - 1);
        st_d     = ST_IDLE;
      end
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_WAIT;
      irefs_q <= '0;
    end else begin
      st_q    <= st_d;
      irefs_q <= irefs_d;
    end
  end

  sdr_pin_drv #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .DQM_W  (DQM_W)
  ) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_d),
    .addr_i    (addr_d),
    .ba_i      (ba_d),
    .ready_d_i (ready_d),
    .cs_n_o    (sd_cs_n_o),
    .ras_n_o   (sd_ras_n_o),
    .cas_n_o   (sd_cas_n_o),
    .we_n_o    (sd_we_n_o),
    .cke_o     (sd_cke_o),
    .dqm_o     (sd_dqm_o),
    .addr_o    (sd_addr_o),
    .ba_o      (sd_ba_o),
    .ready_o   (ready_o)
  );

endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk #(
  parameter int T_RP   = 3,
  parameter int T_RC   = 10,
  parameter int T_MRD  = 2,
  parameter int ADDR_W = 11,
  parameter int BA_W   = 2,
  parameter int DQM_W  = 4,
  parameter int AP_BIT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              cke,
  input logic [DQM_W-1:0]  dqm,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              ready,
  input logic              req
);

  logic [1:0] cur, last_q;
  logic [7:0] since_q;
  int         need;

  always_comb begin
    unique case ({cs_n, ras_n, cas_n, we_n})
      4'b0010: cur = 2'd1;
      4'b0001: cur = 2'd2;
      4'b0000: cur = 2'd3;
      default: cur = 2'd0;
    endcase
    unique case (last_q)
      2'd1:    need = T_RP;
      2'd2:    need = T_RC;
      2'd3:    need = T_MRD;
      default: need = 0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= 2'd0;
      since_q <= '0;
    end else if (cur != 2'd0) begin
      last_q  <= cur;
      since_q <= 8'd1;
    end else if (since_q != 8'hff) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R6
  cke_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cke);

  // R1
  dqm_until_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> (&dqm));

  // R5
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |=> ready);

  // R4
  mrs_before_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready) |-> (last_q == 2'd3));

  // R2
  pre_all_banks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == 2'd1) |-> (addr[AP_BIT] && ba == '0));

  // R3
  cmd_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur != 2'd0) |-> (int'(since_q) >= need));

  // R8
  ref_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && cur == 2'd2) |-> (last_q == 2'd1));

  // R7
  req_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req) |-> (cur == 2'd2));

  // R9
  pre_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && cur == 2'd1) |-> req);

endmodule

bind sdram_pwrup_refresh sdr_seq_chk #(
  .T_RP   (T_RP),
  .T_RC   (T_RC),
  .T_MRD  (T_MRD),
  .ADDR_W (ADDR_W),
  .BA_W   (BA_W),
  .DQM_W  (DQM_W),
  .AP_BIT (AP_BIT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_n   (sd_cs_n_o),
  .ras_n  (sd_ras_n_o),
  .cas_n  (sd_cas_n_o),
  .we_n   (sd_we_n_o),
  .cke    (sd_cke_o),
  .dqm    (sd_dqm_o),
  .addr   (sd_addr_o),
  .ba     (sd_ba_o),
  .ready  (ready_o),
  .req    (ref_req_o)
);

// File: tb/sim_sdram_pwrup_refresh.sv
`timescale 1ns/1ps
module sim_sdram_pwrup_refresh;

  localparam int W     = 50 * 200;
  localparam int RP    = 3;
  localparam int RC    = 10;
  localparam int MRD   = 2;
  localparam int NREF  = 2;
  localparam int REFI  = (50 * 15600) / 1000;
  localparam int MAXD  = 8;
  localparam int MODE  = 'h032;

  localparam int T_PRE = W;
  localparam int T_REF = W + RP;
  localparam int T_MRS = W + RP + NREF * RC;
  localparam int T_RDY = T_MRS + MRD;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_gnt_i = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n, cke, ready, req;
  logic [3:0]  dqm;
  logic [10:0] addr;
  logic [1:0]  ba;

  always #10 clk_i = ~clk_i;

  sdram_pwrup_refresh u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_gnt_i  (ref_gnt_i),
    .sd_cs_n_o  (cs_n),
    .sd_ras_n_o (ras_n),
    .sd_cas_n_o (cas_n),
    .sd_we_n_o  (we_n),
    .sd_cke_o   (cke),
    .sd_dqm_o   (dqm),
    .sd_addr_o  (addr),
    .sd_ba_o    (ba),
    .ready_o    (ready),
    .ref_req_o  (req)
  );

  // reference model state
  int e = 0;
  int ecmd = 0;           // 0 NOP, 1 PRE, 2 REF, 3 MRS
  int erdy = 0;
  int debt = 0;
  int phase = 0;
  int ref_at = 0;
  int next_ok = T_RDY + 1;
  int n_cmp = 0;
  int n_bad = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      e = 0; ecmd = 0; erdy = 0; debt = 0; phase = 0; next_ok = T_RDY + 1;
    end else begin
      automatic logic g = ref_gnt_i;
      automatic int   tick = 0;
      automatic int   dec = 0;
      e++;
      ecmd = 0;
      if (e == T_PRE) ecmd = 1;
      if (e >= T_REF && e < T_MRS && ((e - T_REF) % RC) == 0) ecmd = 2;
      if (e == T_MRS) ecmd = 3;
      if (e == T_RDY) erdy = 1;
      if (e > T_RDY) begin
        tick = (((e - T_RDY) % REFI) == 0) ? 1 : 0;
        if (phase == 0 && e >= next_ok && debt > 0 && g) begin
          ecmd = 1; phase = 1; ref_at = e + RP;
        end else if (phase == 1 && e == ref_at) begin
          ecmd = 2; dec = 1; phase = 0; next_ok = e + RC;
        end
        if (tick == 1 && dec == 0 && debt < MAXD) debt++;
        else if (tick == 0 && dec == 1) debt--;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h", tag, what, e, act, exp);
    end
  endtask

  function automatic int pins_of(input int c);
    case (c)
      1: return 4'b0010;
      2: return 4'b0001;
      3: return 4'b0000;
      default: return 4'b0111;
    endcase
  endfunction

  always @(negedge clk_i) begin
    automatic string t;
    automatic int    eaddr;
    if (!ready && e < T_PRE)    t = "R1";
    else if (erdy == 0 && ecmd == 1) t = "R2";
    else if (erdy == 0 && ecmd == 2) t = "R3";
    else if (ecmd == 3)         t = "R4";
    else if (erdy == 0)         t = "R5";
    else if (ecmd != 0)         t = "R8";
    else                        t = "R9";
    eaddr = (ecmd == 1) ? (1 << 10) : (ecmd == 3) ? MODE : 0;
    chk(t, "cmd pins", int'({cs_n, ras_n, cas_n, we_n}), pins_of(ecmd));
    chk(t, "address", int'(addr), eaddr);
    chk(t, "bank", int'(ba), 0);
    chk("R6", "cke", int'(cke), 1);
    chk("R1", "dqm", int'(dqm), erdy ? 0 : 'hf);
    chk("R5", "ready", int'(ready), erdy);
    chk((debt == MAXD) ? "R10" : "R7", "ref_req", int'(req), (debt > 0) ? 1 : 0);
  end

  task automatic run_until(input int edge_no);
    while (e < edge_no) @(negedge clk_i);
  endtask

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9: grant before ready must do nothing
    ref_gnt_i = 1'b1;
    run_until(T_PRE - 50);
    ref_gnt_i = 1'b0;
    run_until(T_RDY + 5);
    // R8: grant held high, refresh follows each request
    ref_gnt_i = 1'b1;
    run_until(T_RDY + 3 * REFI + 40);
    // R10: withhold grant until owed count saturates
    ref_gnt_i = 1'b0;
    run_until(T_RDY + 14 * REFI + 10);
    ref_gnt_i = 1'b1;
    run_until(T_RDY + 14 * REFI + 200);
    // R9: toggling grant, ignored during a refresh in progress
    for (int i = 0; i < 3 * REFI; i++) begin
      @(negedge clk_i);
      ref_gnt_i = ~ref_gnt_i;
    end
    // R7: pseudo-random grant
    for (int i = 0; i < 4 * REFI; i++) begin
      @(negedge clk_i);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      ref_gnt_i = lcg[16] & lcg[19];
    end
    ref_gnt_i = 1'b1;
    repeat (2 * REFI) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL R5 watchdog: actual=%0d cycles expected=end of run", e);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule